// File: doc/BRIEF.md
# Masked Packed Double-to-Int32 Conversion Unit

This block converts up to eight 64-bit double-precision values into signed 32-bit integers and packs the results, one 32-bit lane per source element, into the low half of a destination vector. It sits in a vector execution pipeline after operand fetch. The caller supplies the source vector, the previous destination value and the control fields of the operation: vector length, write mask, masking style, broadcast, source kind, rounding choices and a legacy-encoding flag. The block returns the new destination vector and the combined exception flags one clock later.

Each lane has its own scalar converter. Per-lane control logic decides whether a lane takes the conversion result, keeps its old value or is cleared. A small selector picks the rounding mode in force for the operation. The result and the flags are registered together, so the whole operation has one cycle of latency.

Top module: `cvt_packed_unit`

## Requirements
- R1: Destination and flags are registered: inputs sampled at one rising edge appear on the outputs after that edge. While `rst_n` is low the destination and both flags are zero.
- R2: `vl_sel` 0, 1 and 2 (3 behaves as 2) select 2, 4 and 8 active lanes. Lane j reads `src_vec[64j+63:64j]` and writes `dst_vec[32j+31:32j]`.
- R3: A rounding code selects the mode. 0 is nearest with ties to even, 1 is toward minus infinity, 2 is toward plus infinity and 3 is toward zero.
- R4: A NaN, an infinity, or a rounded value outside [-2^31, 2^31-1] gives 32'h8000_0000 in that lane and raises the invalid flag for that lane. The lane then reports no precision loss.
- R5: A lane whose valid result differs from its exact source value raises the precision flag.
- R6: An active lane is written when `mask_en` is 0 or its `wmask` bit is 1.
- R7: An active lane that is masked off keeps its `old_dst` lane when `zero_mask` is 0. When `zero_mask` is 1 it is cleared.
- R8: When `bcast` and `mem_src` are both 1, every active lane converts `src_vec[63:0]`. `bcast` with a register source does not replicate.
- R9: `emb_rnd` replaces `glob_rnd` only when `vl_sel` selects 512 bits, `mem_src` is 0 and `bcast` is 1.
- R10: When `legacy` is 0, every destination bit at or above half the selected vector length is zero, including bits 511:256.
- R11: When `legacy` is 1, lanes 0 and 1 are converted from their own source elements with `glob_rnd`, whatever the mask, broadcast and length inputs. Bits 127:64 are zero and bits 511:128 keep `old_dst`.
- R12: `flag_invalid` and `flag_inexact` are the OR of the per-lane flags of written lanes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_vec | input | 512 | Eight double-precision source elements |
| vl_sel | input | 2 | Vector length code |
| wmask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Mask in use |
| zero_mask | input | 1 | 1 clears masked-off lanes, 0 merges old value |
| bcast | input | 1 | Broadcast / rounding-override bit |
| mem_src | input | 1 | Source came from memory |
| emb_rnd | input | 2 | Rounding code carried by the operation |
| glob_rnd | input | 2 | Rounding code from the control register |
| old_dst | input | 512 | Previous destination value |
| legacy | input | 1 | Legacy encoding behaviour |
| dst_vec | output | 512 | New destination value |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Precision flag |

## Verification
Every result of this block, the packed destination and both flags, is due exactly one rising edge after the inputs that produce it. The bench changes its inputs on a falling edge and computes the expected vector from those inputs at that moment. It compares outputs at the next falling edge, half a cycle after the capturing edge, so that the one-cycle latency is checked on every operation. The reset check samples the outputs on falling edges while reset is still held.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;

    typedef enum logic [1:0] {
        RND_NEAR  = 2'd0,
        RND_DOWN  = 2'd1,
        RND_UP    = 2'd2,
        RND_TRUNC = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512X = 2'd3
    } vl_e;

    typedef enum logic [1:0] {
        ACT_WRITE = 2'd0,
        ACT_KEEP  = 2'd1,
        ACT_CLEAR = 2'd2
    } lane_act_e;

endpackage

// File: rtl/cvt_rnd_sel.sv
`timescale 1ns/1ps
module cvt_rnd_sel
    import cvt_pkg::*;
(
    input  logic [1:0] vl_sel,
    input  logic       legacy,
    input  logic       mem_src,
    input  logic       bcast,
    input  logic [1:0] emb_rnd,
    input  logic [1:0] glob_rnd,
    output rnd_e       rnd_eff
);
    vl_e vl_code;
    logic use_emb;

    always_comb begin
        vl_code = vl_e'(vl_sel);
        use_emb = !legacy && !mem_src && bcast &&
                  ((vl_code == VL_512) || (vl_code == VL_512X));
        rnd_eff = use_emb ? rnd_e'(emb_rnd) : rnd_e'(glob_rnd);
    end
endmodule

// File: rtl/cvt_f64_to_i32.sv
`timescale 1ns/1ps
module cvt_f64_to_i32
    import cvt_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] src,
    input  rnd_e                 rnd,
    output logic [INT_W-1:0]     res,
    output logic                 invalid,
    output logic                 inexact
);
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W  = MAN_W + 1;
    localparam int WIDE   = SIG_W + EXP_W;
    localparam int SH_W   = $clog2(WIDE);
    localparam int LO_EXP = BIAS + MAN_W - WIDE + 1;
    localparam int HI_EXP = BIAS + INT_W - 1;
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic [WIDE-1:0]  sig;
    logic [WIDE-1:0]  shifted;
    logic [SH_W-1:0]  sh;
    logic             grd;
    logic             stk;
    logic             out_of_range;
    logic             inc;
    logic             lossy;
    logic [INT_W:0]   mag;
    logic [INT_W:0]   lim;
    logic             ovf;

    assign {sgn, ex, man} = src;

    always_comb begin
        sig          = {{(WIDE-SIG_W){1'b0}}, 1'b1, man};
        shifted      = '0;
        sh           = '0;
        grd          = 1'b0;
        stk          = 1'b0;
        out_of_range = 1'b0;
        if ((&ex) || (int'(ex) > HI_EXP)) begin
            out_of_range = 1'b1;
        end else if (int'(ex) < LO_EXP) begin
            stk = (ex != '0) || (man != '0);
        end else begin
            sh      = SH_W'(BIAS + MAN_W - int'(ex));
            shifted = sig >> sh;
            grd     = |(sig & (WIDE'(1) << (sh - 1'b1)));
            stk     = |(sig & ((WIDE'(1) << (sh - 1'b1)) - WIDE'(1)));
        end

        lossy = grd | stk;
        unique case (rnd)
            RND_NEAR:  inc = grd & (stk | shifted[0]);
            RND_DOWN:  inc = sgn & lossy;
            RND_UP:    inc = ~sgn & lossy;
            default:   inc = 1'b0;
        endcase

        mag = shifted[INT_W:0] + (INT_W+1)'(inc);
        lim = sgn ? (INT_W+1)'(1) << (INT_W - 1)
                  : ((INT_W+1)'(1) << (INT_W - 1)) - (INT_W+1)'(1);
        ovf = out_of_range || (|shifted[WIDE-1:INT_W+1]) || (mag > lim);

        if (ovf) begin
            res = INDEF;
        end else if (sgn) begin
            res = -mag[INT_W-1:0];
        end else begin
            res = mag[INT_W-1:0];
        end
        invalid = ovf;
        inexact = lossy & ~ovf;
    end
endmodule

// File: rtl/cvt_lane_ctrl.sv
`timescale 1ns/1ps
module cvt_lane_ctrl
    import cvt_pkg::*;
(
    input  logic      active,
    input  logic      hold_upper,
    input  logic      legacy,
    input  logic      mask_en,
    input  logic      mask_bit,
    input  logic      zero_mask,
    output lane_act_e act
);
    always_comb begin
        if (active && (legacy || !mask_en || mask_bit)) begin
            act = ACT_WRITE;
        end else if (active && !zero_mask) begin
            act = ACT_KEEP;
        end else if (!active && hold_upper) begin
            act = ACT_KEEP;
        end else begin
            act = ACT_CLEAR;
        end
    end
endmodule

// File: rtl/cvt_packed_unit.sv
`timescale 1ns/1ps
module cvt_packed_unit
    import cvt_pkg::*;
#(
    parameter int MAX_VL    = 512,
    parameter int EXP_W     = 11,
    parameter int MAN_W     = 52,
    parameter int DST_W     = 32,
    parameter int LEGACY_VL = 128
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [MAX_VL-1:0]                   src_vec,
    input  logic [1:0]                          vl_sel,
    input  logic [MAX_VL/(1+EXP_W+MAN_W)-1:0]   wmask,
    input  logic                                mask_en,
    input  logic                                zero_mask,
    input  logic                                bcast,
    input  logic                                mem_src,
    input  logic [1:0]                          emb_rnd,
    input  logic [1:0]                          glob_rnd,
    input  logic [MAX_VL-1:0]                   old_dst,
    input  logic                                legacy,
    output logic [MAX_VL-1:0]                   dst_vec,
    output logic                                flag_invalid,
    output logic                                flag_inexact
);
    localparam int SRC_W     = 1 + EXP_W + MAN_W;
    localparam int LANES     = MAX_VL / SRC_W;
    localparam int PACK_W    = LANES * DST_W;
    localparam int LEG_LANES = LEGACY_VL / SRC_W;
    localparam int HOLD_LANE = LEGACY_VL / DST_W;
    localparam int CNT_W     = $clog2(LANES + 1);

    typedef struct packed {
        logic [MAX_VL-1:0] dst;
        logic              inv;
        logic              inx;
    } state_t;

    state_t st_d, st_q;

    rnd_e             rnd_eff;
    logic [CNT_W-1:0] n_active;
    logic             bcast_src;
    logic [DST_W-1:0] lane_res [LANES];
    logic             lane_inv [LANES];
    logic             lane_inx [LANES];
    lane_act_e        lane_act [LANES];

    cvt_rnd_sel u_rnd (
        .vl_sel  (vl_sel),
        .legacy  (legacy),
        .mem_src (mem_src),
        .bcast   (bcast),
        .emb_rnd (emb_rnd),
        .glob_rnd(glob_rnd),
        .rnd_eff (rnd_eff)
    );

    always_comb begin
        bcast_src = bcast && mem_src && !legacy;
        if (legacy) begin
            n_active = CNT_W'(LEG_LANES);
        end else begin
            unique case (vl_e'(vl_sel))
                VL_128:  n_active = CNT_W'(LANES / 4);
                VL_256:  n_active = CNT_W'(LANES / 2);
                default: n_active = CNT_W'(LANES);
            endcase
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [SRC_W-1:0] elem;
        assign elem = bcast_src ? src_vec[SRC_W-1:0] : src_vec[j*SRC_W +: SRC_W];

        cvt_f64_to_i32 #(
            .EXP_W(EXP_W),
            .MAN_W(MAN_W),
            .INT_W(DST_W)
        ) u_cvt (
            .src    (elem),
            .rnd    (rnd_eff),
            .res    (lane_res[j]),
            .invalid(lane_inv[j]),
            .inexact(lane_inx[j])
        );

        cvt_lane_ctrl u_ctl (
            .active    (CNT_W'(j) < n_active),
            .hold_upper(legacy && (j >= HOLD_LANE)),
            .legacy    (legacy),
            .mask_en   (mask_en),
            .mask_bit  (wmask[j]),
            .zero_mask (zero_mask),
            .act       (lane_act[j])
        );
    end

    always_comb begin
        st_d     = '0;
        for (int j = 0; j < LANES; j++) begin
            unique case (lane_act[j])
                ACT_WRITE: begin
                    st_d.dst[j*DST_W +: DST_W] = lane_res[j];
                    st_d.inv = st_d.inv | lane_inv[j];
                    st_d.inx = st_d.inx | lane_inx[j];
                end
                ACT_KEEP:  st_d.dst[j*DST_W +: DST_W] = old_dst[j*DST_W +: DST_W];
                default:   st_d.dst[j*DST_W +: DST_W] = '0;
            endcase
        end
        if (legacy) begin
            st_d.dst[MAX_VL-1:PACK_W] = old_dst[MAX_VL-1:PACK_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_vec      = st_q.dst;
    assign flag_invalid = st_q.inv;
    assign flag_inexact = st_q.inx;

    a_r7_merge_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !legacy && mask_en && !wmask[0] && !zero_mask)
        |-> dst_vec[DST_W-1:0] == $past(old_dst[DST_W-1:0]));

    a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !legacy && mask_en && !wmask[0] && zero_mask)
        |-> dst_vec[DST_W-1:0] == '0);

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !legacy) |-> dst_vec[MAX_VL-1:PACK_W] == '0);

    a_r10_short_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !legacy && vl_sel == 2'd0)
        |-> dst_vec[PACK_W-1:LEG_LANES*DST_W] == '0);

    a_r11_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && legacy)
        |-> (dst_vec[MAX_VL-1:LEGACY_VL] == $past(old_dst[MAX_VL-1:LEGACY_VL]))
            && (dst_vec[LEGACY_VL-1:LEG_LANES*DST_W] == '0));

    a_r12_no_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !legacy && mask_en && wmask == '0)
        |-> !flag_invalid && !flag_inexact);

    a_r4_invalid_excludes_precision: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (legacy || !mask_en) && vl_sel == 2'd0 && !bcast
              && src_vec[62:52] == 11'h7FF && src_vec[126:116] == 11'h7FF)
        |-> flag_invalid && !flag_inexact);
endmodule

// File: tb/sim_cvt_packed_unit.sv
`timescale 1ns/1ps
module sim_cvt_packed_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] src_vec = '0;
    logic [1:0]   vl_sel = '0;
    logic [7:0]   wmask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mask = 1'b0;
    logic         bcast = 1'b0;
    logic         mem_src = 1'b0;
    logic [1:0]   emb_rnd = '0;
    logic [1:0]   glob_rnd = '0;
    logic [511:0] old_dst = '0;
    logic         legacy = 1'b0;
    logic [511:0] dst_vec;
    logic         flag_invalid;
    logic         flag_inexact;

    int checks = 0;
    int errors = 0;
    logic [511:0] exp_dst;
    logic         exp_inv, exp_inx;

    always #10 clk = ~clk;

    cvt_packed_unit u0 (.*);

    localparam logic [63:0] D_1P5   = 64'h3FF8000000000000;
    localparam logic [63:0] D_1P25  = 64'h3FF4000000000000;
    localparam logic [63:0] D_2P5   = 64'h4004000000000000;
    localparam logic [63:0] D_M2P5  = 64'hC004000000000000;
    localparam logic [63:0] D_M1P5  = 64'hBFF8000000000000;
    localparam logic [63:0] D_3P75  = 64'h400E000000000000;
    localparam logic [63:0] D_M0P5  = 64'hBFE0000000000000;
    localparam logic [63:0] D_0P5   = 64'h3FE0000000000000;
    localparam logic [63:0] D_TINY  = 64'h0010000000000000;
    localparam logic [63:0] D_MTINY = 64'h8010000000000000;
    localparam logic [63:0] D_INF   = 64'h7FF0000000000000;
    localparam logic [63:0] D_NAN   = 64'h7FF8000000000000;
    localparam logic [63:0] D_P2_31 = 64'h41E0000000000000;
    localparam logic [63:0] D_M2_31 = 64'hC1E0000000000000;
    localparam logic [63:0] D_MAXI  = 64'h41DFFFFFFFC00000;
    localparam logic [63:0] D_MLOW  = 64'hC1E0000000100000;

    task automatic conv_ref(input logic [63:0] b, input logic [1:0] rm,
                            output logic [31:0] r, output logic inv, output logic inx);
        real x, fl, rr, d;
        longint li;
        inv = 1'b0; inx = 1'b0; r = 32'h8000_0000;
        if (b[62:52] == 11'h7FF) begin
            inv = 1'b1;
            return;
        end
        x = $bitstoreal(b);
        if (x >= 8589934592.0 || x <= -8589934592.0) begin
            inv = 1'b1;
            return;
        end
        fl = $floor(x);
        case (rm)
            2'd0: begin
                d  = x - fl;
                li = longint'(fl);
                if (d > 0.5) rr = fl + 1.0;
                else if (d < 0.5) rr = fl;
                else rr = li[0] ? fl + 1.0 : fl;
            end
            2'd1: rr = fl;
            2'd2: rr = $ceil(x);
            default: rr = (x >= 0.0) ? fl : $ceil(x);
        endcase
        if (rr < -2147483648.0 || rr > 2147483647.0) begin
            inv = 1'b1;
            return;
        end
        r   = 32'($rtoi(rr));
        inx = (rr != x);
    endtask

    task automatic model();
        int n;
        logic [1:0] rm;
        logic [63:0] e;
        logic [31:0] r;
        logic iv, ix, wr;
        n = legacy ? 2 : (vl_sel == 2'd0 ? 2 : (vl_sel == 2'd1 ? 4 : 8));
        rm = (!legacy && vl_sel[1] && !mem_src && bcast) ? emb_rnd : glob_rnd;
        exp_dst = '0; exp_inv = 1'b0; exp_inx = 1'b0;
        if (legacy) exp_dst[511:128] = old_dst[511:128];
        for (int j = 0; j < n; j++) begin
            e  = (bcast && mem_src && !legacy) ? src_vec[63:0] : src_vec[j*64 +: 64];
            wr = legacy || !mask_en || wmask[j];
            if (wr) begin
                conv_ref(e, rm, r, iv, ix);
                exp_dst[j*32 +: 32] = r;
                exp_inv = exp_inv | iv;
                exp_inx = exp_inx | ix;
            end else if (!zero_mask) begin
                exp_dst[j*32 +: 32] = old_dst[j*32 +: 32];
            end
        end
    endtask

    task automatic run(input string tag);
        model();
        @(negedge clk);
        checks++;
        if (dst_vec !== exp_dst) begin
            errors++;
            $display("FAIL %s dst got %h exp %h", tag, dst_vec, exp_dst);
        end
        checks++;
        if ({flag_invalid, flag_inexact} !== {exp_inv, exp_inx}) begin
            errors++;
            $display("FAIL %s flags(inv,inx) got %b%b exp %b%b", tag,
                     flag_invalid, flag_inexact, exp_inv, exp_inx);
        end
    endtask

    function automatic logic [63:0] rand_dbl();
        logic [63:0] v;
        case ($urandom % 10)
            0: v = D_NAN;
            1: v = D_MLOW;
            2: v = D_P2_31;
            3: v = D_TINY;
            default: begin
                v[63]    = 1'($urandom);
                v[62:52] = 11'(1010 + ($urandom % 48));
                v[51:0]  = {20'($urandom), 32'($urandom)};
            end
        endcase
        return v;
    endfunction

    task automatic set_src8(input logic [63:0] a0, a1, a2, a3, a4, a5, a6, a7);
        src_vec = {a7, a6, a5, a4, a3, a2, a1, a0};
    endtask

    task automatic rand_old();
        for (int k = 0; k < 16; k++) old_dst[k*32 +: 32] = $urandom;
    endtask

    task automatic ctl(input logic [1:0] vl, input logic me, input logic [7:0] m,
                       input logic zm, input logic bc, input logic ms,
                       input logic [1:0] er, input logic [1:0] gr, input logic lg);
        vl_sel = vl; mask_en = me; wmask = m; zero_mask = zm; bcast = bc;
        mem_src = ms; emb_rnd = er; glob_rnd = gr; legacy = lg;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_src8(D_1P5, D_2P5, D_3P75, D_NAN, D_1P5, D_1P5, D_1P5, D_1P5);
        rand_old();
        ctl(2'd2, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (dst_vec !== '0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset got %h %b%b exp 0", dst_vec, flag_invalid, flag_inexact);
            end
        end
        rst_n = 1'b1;

        // R1 R2 R10: 128-bit length, two lanes, rest zero
        set_src8(D_1P5, D_2P5, D_3P75, D_M1P5, D_0P5, D_M0P5, D_M2P5, D_3P75);
        ctl(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R1 R2 R10 vl128");
        ctl(2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R2 R10 vl256");
        ctl(2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R2 vl code 3");

        // R3 R5: every rounding mode on ties, fractions and tiny values
        set_src8(D_1P5, D_M2P5, D_2P5, D_M1P5, D_3P75, D_M0P5, D_TINY, D_MTINY);
        for (int m = 0; m < 4; m++) begin
            ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'(m), 1'b0);
            run($sformatf("R3 R5 mode %0d", m));
        end

        // R4: specials and range edges
        set_src8(D_INF, D_NAN, D_P2_31, D_M2_31, D_MAXI, D_MLOW, 64'h0, 64'h8000000000000000);
        ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R4 nearest");
        ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0);
        run("R4 down");
        set_src8(D_MAXI, D_M2_31, D_MAXI, D_M2_31, 64'h0, 64'h0, 64'h0, 64'h0);
        ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0);
        run("R4 exact edges no flag");

        // R6 R7: masking
        set_src8(D_1P5, D_2P5, D_3P75, D_M1P5, D_0P5, D_M0P5, D_M2P5, D_1P25);
        rand_old();
        ctl(2'd2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R6 R7 merge");
        ctl(2'd2, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R6 R7 zero");
        ctl(2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R6 mask ignored when disabled");

        // R8 R9: broadcast and rounding override
        set_src8(D_1P25, D_2P5, D_3P75, D_M1P5, D_0P5, D_M0P5, D_M2P5, D_1P5);
        ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0);
        run("R8 broadcast memory");
        ctl(2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0);
        run("R8 R9 register no broadcast vl256");
        ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0);
        run("R9 embedded rounding up");
        ctl(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, 2'd3, 1'b0);
        run("R9 global rounding");

        // R11: legacy behaviour
        rand_old();
        ctl(2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 1'b1);
        run("R11 legacy");

        // R12: flags only from written lanes
        set_src8(D_1P5, D_2P5, D_3P75, D_NAN, D_0P5, D_M0P5, D_M2P5, D_1P5);
        ctl(2'd2, 1'b1, 8'h08, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0);
        run("R12 only invalid lane written");
        ctl(2'd2, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R12 nothing written");
        ctl(2'd0, 1'b1, 8'hFC, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
        run("R12 R2 inactive lanes ignored");

        // R4 R6 R7 R8 R11: random operations back to back
        for (int t = 0; t < 400; t++) begin
            for (int k = 0; k < 8; k++) src_vec[k*64 +: 64] = rand_dbl();
            rand_old();
            ctl(2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 2'($urandom), 2'($urandom), ($urandom % 5) == 0);
            run("R4 R6 R7 R8 R11 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule